// File: doc/BRIEF.md
# Predicated Mask Find-First Unit

This unit scans a source mask vector for its lowest set element and writes a destination mask derived from that position. A predicate mask selects which elements take part: elements with a predicate bit of 0 are skipped by the search, and their destination bits are copied from an old-destination input. Only elements with a predicate bit of 1 are written with a new value.

Three derivations are supported. The first sets every active element that lies strictly below the first active set source bit. The second sets those same elements and also the first active set element. The third sets only that first active set element. A fourth mode code returns the old destination unchanged. A request is presented with a valid strobe. The result appears on a registered output one clock later, flagged by an output valid.

Top module: `mff_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_dest` is all zeros until the first accepted request.
- R2: A request accepted with `in_valid` = 1 on a rising clock edge produces `out_valid` = 1 and its result on `out_dest` after exactly that edge, and `out_valid` is 0 after any edge where `in_valid` was 0.
- R3: For every element i with `pred_mask[i]` = 0, `out_dest[i]` equals `old_dest[i]` of the request.
- R4: Source bits at positions whose predicate bit is 0 have no effect on which element is taken as the first set element.
- R5: With `mode` = 2'b00, the search starts at index 0, the least significant bit, and moves upward. Every active element below the first active element with a source bit of 1 is written 1. That element and every active element above it are written 0.
- R6: With `mode` = 2'b01, every active element below the first active set element is written 1, the first active set element is written 1, and every active element above it is written 0.
- R7: With `mode` = 2'b10, the first active element with a source bit of 1 is written 1 and every other active element is written 0, so at most one active bit of the result is 1.
- R8: When no active element has a source bit of 1, modes 2'b00 and 2'b01 write 1 to every active element, and mode 2'b10 writes 0 to every active element.
- R9: With `mode` = 2'b11, `out_dest` equals `old_dest` of the request in every bit.
- R10: `out_dest` holds its value across every clock edge on which `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Request strobe; the inputs below are sampled when it is 1 |
| mode | input | 2 | 00 before-first, 01 including-first, 10 only-first, 11 pass old destination |
| src_mask | input | VL | Source mask searched for its first active set element |
| pred_mask | input | VL | Predicate; 1 marks an active element |
| old_dest | input | VL | Previous destination, kept at inactive positions |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_dest | output | VL | Registered destination mask |

## Verification
The hardest case to reach is one where an inactive position holds a set source bit below the first active set bit. A design that forgets to apply the predicate to the search would then stop early. Directed requests place set source bits under zero predicate bits at low indices with the real first hit higher up. Random requests across all four modes, with sparse predicates, reach the same situation often and also cover empty-predicate and no-hit vectors. Back-to-back requests followed by idle gaps with changing inputs check the one-cycle latency and the hold behaviour.

// File: rtl/mff_pkg.sv
package mff_pkg;

  typedef enum logic [1:0] {
    MFF_BEFORE = 2'b00,
    MFF_INCL   = 2'b01,
    MFF_ONLY   = 2'b10,
    MFF_KEEP   = 2'b11
  } mff_mode_e;

endpackage

// File: rtl/mff_locate.sv
// Prefix scan from index 0 upward over the predicated source.
module mff_locate #(
  parameter int VL = 8
) (
  input  logic [VL-1:0] src_mask,
  input  logic [VL-1:0] pred_mask,
  output logic [VL-1:0] first_oh,
  output logic [VL-1:0] open_pfx
);

  logic [VL-1:0] eff;
  logic [VL-1:0] seen;

  assign eff = src_mask & pred_mask;

  genvar gi;
  generate
    for (gi = 0; gi < VL; gi++) begin : g_scan
      if (gi == 0) begin : g_lo
        assign seen[gi] = 1'b0;
      end else begin : g_hi
        assign seen[gi] = seen[gi-1] | eff[gi-1];
      end
      assign first_oh[gi] = eff[gi] & ~seen[gi];
      assign open_pfx[gi] = ~seen[gi];
    end
  endgenerate

endmodule

// File: rtl/mff_compose.sv
// Chooses the per-mode value and merges it with the old destination.
module mff_compose #(
  parameter int VL = 8
) (
  input  mff_pkg::mff_mode_e mode,
  input  logic [VL-1:0]      first_oh,
  input  logic [VL-1:0]      open_pfx,
  input  logic [VL-1:0]      pred_mask,
  input  logic [VL-1:0]      old_dest,
  output logic [VL-1:0]      dest_nxt
);
  import mff_pkg::*;

  logic [VL-1:0] val;

  always_comb begin
    case (mode)
      MFF_BEFORE: val = open_pfx & ~first_oh;
      MFF_INCL:   val = open_pfx;
      MFF_ONLY:   val = first_oh;
      default:    val = old_dest;
    endcase
    dest_nxt = (pred_mask & val) | (~pred_mask & old_dest);
  end

endmodule

// File: rtl/mff_unit.sv
module mff_unit #(
  parameter int VL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    mode,
  input  logic [VL-1:0] src_mask,
  input  logic [VL-1:0] pred_mask,
  input  logic [VL-1:0] old_dest,
  output logic          out_valid,
  output logic [VL-1:0] out_dest
);
  import mff_pkg::*;

  mff_mode_e     mode_e;
  logic [VL-1:0] first_oh;
  logic [VL-1:0] open_pfx;
  logic [VL-1:0] dest_nxt;
  logic [VL-1:0] dest_d;
  logic          vld_d;

  assign mode_e = mff_mode_e'(mode);

  mff_locate #(.VL(VL)) u_locate (
    .src_mask  (src_mask),
    .pred_mask (pred_mask),
    .first_oh  (first_oh),
    .open_pfx  (open_pfx)
  );

  mff_compose #(.VL(VL)) u_compose (
    .mode      (mode_e),
    .first_oh  (first_oh),
    .open_pfx  (open_pfx),
    .pred_mask (pred_mask),
    .old_dest  (old_dest),
    .dest_nxt  (dest_nxt)
  );

  // next state: clock enable on in_valid
  always_comb begin
    vld_d  = in_valid;
    dest_d = in_valid ? dest_nxt : out_dest;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dest  <= '0;
    end else begin
      out_valid <= vld_d;
      out_dest  <= dest_d;
    end
  end

  // R2: one-cycle latency of the valid flag
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3: inactive bits come from the old destination
  a_r3_inactive_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_dest ^ $past(old_dest)) & ~$past(pred_mask)) == '0);
  // R7: only-first leaves at most one active bit set
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10) |=> $countones(out_dest & $past(pred_mask)) <= 1);
  // R9: pass-through code
  a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> out_dest == $past(old_dest));
  // R10: hold while idle
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_dest));

endmodule

// File: tb/mff_unit_bench.sv
`timescale 1ns/1ps
module mff_unit_bench;
  localparam int VL = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    mode;
  logic [VL-1:0] src_mask, pred_mask, old_dest;
  logic          out_valid;
  logic [VL-1:0] out_dest;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [VL-1:0] exp;
    string         tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  mff_unit #(.VL(VL)) u_mff_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .src_mask(src_mask), .pred_mask(pred_mask), .old_dest(old_dest),
    .out_valid(out_valid), .out_dest(out_dest)
  );

  function automatic logic [VL-1:0] model(input logic [1:0] m,
      input logic [VL-1:0] s, input logic [VL-1:0] p, input logic [VL-1:0] o);
    logic [VL-1:0] r;
    logic found;
    r = o;
    found = 1'b0;
    if (m == 2'b11) return o;
    for (int i = 0; i < VL; i++) begin
      if (p[i]) begin
        if (!found && s[i]) begin
          r[i] = (m != 2'b00);
          found = 1'b1;
        end else if (!found) begin
          r[i] = (m != 2'b10);
        end else begin
          r[i] = 1'b0;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: apply one request at a falling edge, queue its expectation
  task automatic drive(input logic [1:0] m, input logic [VL-1:0] s,
      input logic [VL-1:0] p, input logic [VL-1:0] o,
      input logic [VL-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; mode = m; src_mask = s; pred_mask = p; old_dest = o;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drive_m(input logic [1:0] m, input logic [VL-1:0] s,
      input logic [VL-1:0] p, input logic [VL-1:0] o, input string tag);
    drive(m, s, p, o, model(m, s, p, o), tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      mode = 2'($urandom); src_mask = VL'($urandom);
      pred_mask = VL'($urandom); old_dest = VL'($urandom);
    end
  endtask

  // monitor: compare results as they appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: out_valid 1 with no request pending");
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, out_dest, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [VL-1:0] held;
    rst_n = 1'b0; in_valid = 1'b0; mode = 2'b00;
    src_mask = '0; pred_mask = '0; old_dest = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {7'b0, out_valid}, 8'h00);
    check("R1 out_dest in reset", out_dest, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 out_valid after release", {7'b0, out_valid}, 8'h00);
    check("R1 out_dest after release", out_dest, 8'h00);

    // hand-worked: pred 11000011, src 10010100, old 00111100
    drive(2'b00, 8'b1001_0100, 8'b1100_0011, 8'b0011_1100, 8'b0111_1111, "R5 before-first example");
    drive(2'b01, 8'b1001_0100, 8'b1100_0011, 8'b0011_1100, 8'b1111_1111, "R6 including-first example");
    drive(2'b10, 8'b1001_0100, 8'b1100_0011, 8'b0011_1100, 8'b1011_1100, "R7 only-first example");
    // first hit at index 0
    drive(2'b00, 8'b0000_0001, 8'hFF, 8'hFF, 8'h00, "R5 hit at index 0");
    drive(2'b01, 8'b0000_0001, 8'hFF, 8'h00, 8'h01, "R6 hit at index 0");
    // R4: inactive set bits below the real hit at bit 5
    drive(2'b00, 8'b0010_0111, 8'b1111_0000, 8'h00, 8'b0001_0000, "R4 before-first skips inactive");
    drive(2'b10, 8'b0010_0111, 8'b1111_0000, 8'h0F, 8'b0010_1111, "R4 only-first skips inactive");
    // R8: no active hit
    drive(2'b00, 8'b0000_1111, 8'b1111_0000, 8'h00, 8'hF0, "R8 before-first no hit");
    drive(2'b01, 8'h00, 8'hFF, 8'h00, 8'hFF, "R8 including-first no hit");
    drive(2'b10, 8'b0101_0101, 8'b1010_1010, 8'hFF, 8'b0101_0101, "R8 only-first no hit");
    // R3: no active elements at all
    drive(2'b01, 8'hFF, 8'h00, 8'h5A, 8'h5A, "R3 empty predicate");
    // R9
    drive(2'b11, 8'hFF, 8'hFF, 8'hC3, 8'hC3, "R9 pass-through");

    // R10: hold while idle with changing inputs
    idle(1);
    @(negedge clk);
    held = out_dest;
    idle(3);
    @(negedge clk);
    check("R10 hold while idle", out_dest, held);
    check("R2 out_valid low while idle", {7'b0, out_valid}, 8'h00);

    // random back-to-back and gapped traffic over every mode
    for (int n = 0; n < 400; n++) begin
      logic [VL-1:0] p;
      p = VL'($urandom);
      if (n % 3 == 0) p = p & VL'($urandom);
      drive_m(2'($urandom), VL'($urandom) & VL'($urandom), p, VL'($urandom), "R3-R9 random");
      if (n % 7 == 0) idle(2);
    end
    idle(4);
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: %0d results missing, expected 0", sb.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule